// File: doc/BRIEF.md
# ECC Error Status and Control Register

This block is one 32-bit software-visible register that sits beside a DRAM memory controller's error-checking datapath. The datapath reports two kinds of events as single-cycle pulses: a corrected (single-bit) error and an uncorrectable error. Each pulse comes with the 4-bit number of the chip-select row that was being accessed. The register keeps one sticky flag per event kind, and a captured row number for each kind. It also holds the checking mode, a diagnostic enable and one interrupt enable per event kind. From these it drives a registered error interrupt.

Software polls or takes the interrupt and reads the register. It works out which kinds of event happened and on which rows. It then acknowledges each kind on its own by writing a one to that kind's flag bit. Every write also loads the control fields from the written word. Software that only wants to acknowledge must therefore write back the control values it wants to keep.

Top module: `ecc_err_status_reg`

## Requirements
- R1: After reset the register reads 0x00000000, and both the interrupt output and the active output are low.
- R2: Bits 31:16 and bit 13 always read zero, whatever value is written.
- R3: The control fields read back as last written: bits 11:10 checking mode (0 off, 1 detect only, 2 correct, 3 correct with scrub), bit 12 diagnostic enable, bit 14 uncorrectable interrupt enable, bit 15 corrected interrupt enable.
- R4: While the mode is nonzero, an uncorrectable pulse sets bit 8 and loads its row into bits 7:4. A corrected pulse sets bit 9 and loads its row into bits 3:0. The result is visible in the cycle after the pulse.
- R5: While a flag is set, its row field keeps the first captured row; later events of the same kind do not change it. After the flag clears, the row field keeps its value until the next capture.
- R6: A write with a one in bit 8 or bit 9 clears that flag. A zero in a flag bit leaves that flag unchanged, so each kind is acknowledged independently.
- R7: While the mode is 0, event pulses change no flag, no row field and no interrupt.
- R8: If a clearing write and a new event of the same kind fall in the same cycle, the flag stays set and the row field takes the new event's row.
- R9: The interrupt output is a register holding the OR over both kinds of (flag AND that kind's enable). It follows any change of flags or enables one cycle later.
- R10: The active output is high exactly when the mode field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ue_pulse_i | input | 1 | Uncorrectable error event, one cycle |
| ue_row_i | input | 4 | Chip-select row of the uncorrectable event |
| ce_pulse_i | input | 1 | Corrected error event, one cycle |
| ce_row_i | input | 4 | Chip-select row of the corrected event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (current contents) |
| err_irq_o | output | 1 | Registered error interrupt |
| ecc_active_o | output | 1 | High while checking mode is nonzero |

## Verification
A flag set wrongly or left set after a clear shows on the read port in the very next cycle. It also shows on the interrupt one cycle after that, if that kind is enabled. A row field that was overwritten while frozen, or not loaded on a capture, shows only on the read port, one cycle after the offending pulse. The bench therefore reads back after every pulse and every write. A wrong interrupt register is caught by sampling the interrupt in both cycles after each flag or enable change, so a missing or extra cycle of delay is seen.

// File: rtl/ecc_stat_pkg.sv
`timescale 1ns/1ps
package ecc_stat_pkg;
  localparam int REG_W    = 32;
  localparam int ROW_W    = 4;
  localparam int NKIND    = 2;
  localparam int KIND_UE  = 0;
  localparam int KIND_CE  = 1;
  localparam int FLAG_LSB = 8;
  localparam int MODE_LSB = 10;
  localparam int MODE_W   = 2;
  localparam int DIAG_BIT = 12;
  localparam int EN_LSB   = 14;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 2'd0,
    MODE_DETECT  = 2'd1,
    MODE_CORRECT = 2'd2,
    MODE_SCRUB   = 2'd3
  } ecc_mode_e;

  // Row fields are packed from bit 0 upward in reverse kind order:
  // corrected row lowest, uncorrectable row above it.
  function automatic int row_lsb(input int kind);
    return (NKIND - 1 - kind) * ROW_W;
  endfunction
endpackage

// File: rtl/ecc_err_chan.sv
`timescale 1ns/1ps
module ecc_err_chan #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             evt_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [ROW_W-1:0] row_o
);
  logic             flag_q, flag_d;
  logic [ROW_W-1:0] row_q;
  logic             take;
  logic             row_en;

  always_comb begin
    take   = arm_i && evt_i;
    row_en = take && (!flag_q || clr_i);
    flag_d = flag_q;
    if (take)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (row_en) row_q <= row_i;
    end
  end

  assign flag_o = flag_q;
  assign row_o  = row_q;
endmodule

// File: rtl/ecc_ctrl_regs.sv
`timescale 1ns/1ps
module ecc_ctrl_regs
  import ecc_stat_pkg::*;
#(
  parameter int N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  ecc_mode_e   mode_wr_i,
  input  logic        diag_wr_i,
  input  logic [N-1:0] en_wr_i,
  output ecc_mode_e   mode_o,
  output logic        diag_o,
  output logic [N-1:0] en_o
);
  ecc_mode_e    mode_q, mode_d;
  logic         diag_q, diag_d;
  logic [N-1:0] en_q, en_d;

  always_comb begin
    mode_d = mode_q;
    diag_d = diag_q;
    en_d   = en_q;
    if (wr_i) begin
      mode_d = mode_wr_i;
      diag_d = diag_wr_i;
      en_d   = en_wr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      diag_q <= 1'b0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      diag_q <= diag_d;
      en_q   <= en_d;
    end
  end

  assign mode_o = mode_q;
  assign diag_o = diag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/ecc_irq_gen.sv
`timescale 1ns/1ps
module ecc_irq_gen #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(flag_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ecc_err_status_reg.sv
`timescale 1ns/1ps
module ecc_err_status_reg
  import ecc_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ue_pulse_i,
  input  logic [ROW_W-1:0] ue_row_i,
  input  logic             ce_pulse_i,
  input  logic [ROW_W-1:0] ce_row_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             err_irq_o,
  output logic             ecc_active_o
);
  logic [NKIND-1:0]            evt;
  logic [NKIND-1:0][ROW_W-1:0] row_in;
  logic [NKIND-1:0]            clr;
  logic [NKIND-1:0]            flag;
  logic [NKIND-1:0][ROW_W-1:0] row_cap;
  logic [NKIND-1:0]            en;
  ecc_mode_e                   mode;
  logic                        diag;
  logic                        armed;
  logic                        unused_wbits;

  assign evt[KIND_UE]    = ue_pulse_i;
  assign evt[KIND_CE]    = ce_pulse_i;
  assign row_in[KIND_UE] = ue_row_i;
  assign row_in[KIND_CE] = ce_row_i;
  assign armed           = (mode != MODE_OFF);
  assign unused_wbits    = ^{reg_wdata_i[REG_W-1:EN_LSB+NKIND],
                             reg_wdata_i[DIAG_BIT+1],
                             reg_wdata_i[FLAG_LSB-1:0]};

  ecc_ctrl_regs #(.N(NKIND)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .mode_wr_i (ecc_mode_e'(reg_wdata_i[MODE_LSB +: MODE_W])),
    .diag_wr_i (reg_wdata_i[DIAG_BIT]),
    .en_wr_i   (reg_wdata_i[EN_LSB +: NKIND]),
    .mode_o    (mode),
    .diag_o    (diag),
    .en_o      (en)
  );

  for (genvar k = 0; k < NKIND; k++) begin : g_chan
    assign clr[k] = reg_wr_i && reg_wdata_i[FLAG_LSB + k];

    ecc_err_chan #(.ROW_W(ROW_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (armed),
      .evt_i  (evt[k]),
      .row_i  (row_in[k]),
      .clr_i  (clr[k]),
      .flag_o (flag[k]),
      .row_o  (row_cap[k])
    );
  end

  ecc_irq_gen #(.N(NKIND)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (flag),
    .en_i   (en),
    .irq_o  (err_irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NKIND; k++) begin
      reg_rdata_o[FLAG_LSB + k]           = flag[k];
      reg_rdata_o[EN_LSB + k]             = en[k];
      reg_rdata_o[row_lsb(k) +: ROW_W]    = row_cap[k];
    end
    reg_rdata_o[MODE_LSB +: MODE_W] = mode;
    reg_rdata_o[DIAG_BIT]           = diag;
  end

  assign ecc_active_o = armed;
endmodule

// File: rtl/ecc_err_status_chk.sv
`timescale 1ns/1ps
module ecc_err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ue_pulse_i,
  input logic [3:0]  ue_row_i,
  input logic        ce_pulse_i,
  input logic [3:0]  ce_row_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        err_irq_o,
  input logic        ecc_active_o
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[31:16] == 16'h0) && !reg_rdata_o[13]);

  a_r4_ue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse_i && reg_rdata_o[11:10] != 2'd0) |=> reg_rdata_o[8]);

  a_r4_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pulse_i && reg_rdata_o[11:10] != 2'd0) |=> reg_rdata_o[9]);

  a_r5_ue_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[8] && !(reg_wr_i && reg_wdata_i[8])) |=> $stable(reg_rdata_o[7:4]));

  a_r5_ce_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[9] && !(reg_wr_i && reg_wdata_i[9])) |=> $stable(reg_rdata_o[3:0]));

  a_r6_ue_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[8] && !ue_pulse_i) |=> !reg_rdata_o[8]);

  a_r7_off_no_ue: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[11:10] == 2'd0 && !reg_rdata_o[8]) |=> !reg_rdata_o[8]);

  a_r8_ue_new_row: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse_i && reg_rdata_o[11:10] != 2'd0 && reg_wr_i && reg_wdata_i[8])
      |=> (reg_rdata_o[8] && reg_rdata_o[7:4] == $past(ue_row_i)));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_irq_o == $past((reg_rdata_o[8] && reg_rdata_o[14]) ||
                                 (reg_rdata_o[9] && reg_rdata_o[15]))));

  a_r10_active: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_active_o == (reg_rdata_o[11:10] != 2'd0));
endmodule

bind ecc_err_status_reg ecc_err_status_chk u_chk (.*);

// File: tb/tb_ecc_err_status_reg.sv
`timescale 1ns/1ps
module tb_ecc_err_status_reg;
  logic        clk;
  logic        rst_n;
  logic        ue_p, ce_p, wr;
  logic [3:0]  ue_r, ce_r;
  logic [31:0] wd, rd;
  logic        irq, act;
  int          n_chk, n_err;
  bit          done;
  logic [3:0]  xu, xc;

  ecc_err_status_reg dut (
    .clk(clk), .rst_n(rst_n),
    .ue_pulse_i(ue_p), .ue_row_i(ue_r),
    .ce_pulse_i(ce_p), .ce_row_i(ce_r),
    .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .err_irq_o(irq), .ecc_active_o(act)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, a, e);
    end
  endtask

  task automatic wr_reg(input logic [31:0] v);
    wr = 1'b1; wd = v;
    @(negedge clk);
    wr = 1'b0; wd = '0;
  endtask

  task automatic pulse(input logic u, input logic [3:0] ur, input logic c, input logic [3:0] cr);
    ue_p = u; ue_r = ur; ce_p = c; ce_r = cr;
    @(negedge clk);
    ue_p = 1'b0; ce_p = 1'b0;
  endtask

  function automatic logic [31:0] img(input int m, input int fl, input logic [3:0] u, input logic [3:0] c, input int hi);
    return 32'(hi) | 32'(m << 10) | 32'(fl << 8) | {24'h0, u, c};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    ue_p = 0; ce_p = 0; ue_r = 0; ce_r = 0; wr = 0; wd = 0;
    xu = 4'h0; xc = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset read", rd, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    chk("R1 reset active", {31'h0, act}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R3, R10: sweep every control combination with reserved bits set
    for (int c = 0; c < 32; c++) begin
      logic [31:0] e;
      e = 32'((c >> 3) << 14) | 32'(((c >> 2) & 1) << 12) | 32'((c & 3) << 10);
      wr_reg(32'hFFFF_2000 | e);
      chk("R3 control readback", rd & 32'h0000_DC00, e);
      chk("R2 reserved zero", rd & 32'hFFFF_2000, 32'h0);
      chk("R10 active", {31'h0, act}, {31'h0, (c & 3) != 0});
    end

    // R4 and R7: every mode, every row
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 16; r++) begin
        wr_reg(32'(m << 10));
        pulse(1'b1, 4'(r), 1'b1, 4'(15 - r));
        if (m != 0) begin
          xu = 4'(r); xc = 4'(15 - r);
          chk("R4 capture both", rd, img(m, 3, xu, xc, 0));
        end else begin
          chk("R7 off ignores", rd, img(0, 0, xu, xc, 0));
        end
        wr_reg(32'(m << 10) | 32'h300);
        chk("R6 clear both", rd, img(m, 0, xu, xc, 0));
      end
    end

    // R5: frozen rows
    wr_reg(32'h400);
    pulse(1'b1, 4'd3, 1'b0, 4'd0);  xu = 4'd3;
    chk("R4 ue capture", rd, img(1, 1, xu, xc, 0));
    pulse(1'b1, 4'd9, 1'b1, 4'd5);  xc = 4'd5;
    chk("R5 ue row frozen", rd, img(1, 3, xu, xc, 0));
    pulse(1'b0, 4'd0, 1'b1, 4'd12);
    chk("R5 ce row frozen", rd, img(1, 3, xu, xc, 0));

    // R6: independent acknowledge
    wr_reg(32'h500);
    chk("R6 clear ue only", rd, img(1, 2, xu, xc, 0));
    wr_reg(32'h600);
    chk("R6 clear ce, rows kept", rd, img(1, 0, xu, xc, 0));
    wr_reg(32'h400);
    chk("R6 zero write no effect", rd, img(1, 0, xu, xc, 0));

    // R8: clear and new event collide
    pulse(1'b1, 4'd2, 1'b1, 4'd4);  xu = 4'd2; xc = 4'd4;
    chk("R8 setup", rd, img(1, 3, xu, xc, 0));
    wr = 1'b1; wd = 32'h500; ue_p = 1'b1; ue_r = 4'd11;
    @(negedge clk);
    wr = 1'b0; wd = 0; ue_p = 1'b0; xu = 4'd11;
    chk("R8 ue new row wins", rd, img(1, 3, xu, xc, 0));
    wr = 1'b1; wd = 32'h600; ce_p = 1'b1; ce_r = 4'd13;
    @(negedge clk);
    wr = 1'b0; wd = 0; ce_p = 1'b0; xc = 4'd13;
    chk("R8 ce new row wins", rd, img(1, 3, xu, xc, 0));
    wr_reg(32'h700);

    // R9: interrupt timing
    wr_reg(32'h4400);
    pulse(1'b1, 4'd6, 1'b0, 4'd0);  xu = 4'd6;
    chk("R9 irq one-cycle lag", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq asserted", {31'h0, irq}, 32'h1);
    pulse(1'b0, 4'd0, 1'b1, 4'd7);  xc = 4'd7;
    wr_reg(32'h4500);
    chk("R9 flag cleared", rd, img(1, 2, xu, xc, 32'h4000));
    chk("R9 irq still high", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq low, ce not enabled", {31'h0, irq}, 32'h0);
    wr_reg(32'h8400);
    chk("R9 irq lag after enable", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq by ce enable", {31'h0, irq}, 32'h1);
    wr_reg(32'h8600);
    chk("R9 irq held one cycle", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);

    // R7: mode off with interrupts enabled
    wr_reg(32'hC000);
    pulse(1'b1, 4'd1, 1'b1, 4'd2);
    @(negedge clk);
    chk("R7 off read", rd, img(0, 0, xu, xc, 32'hC000));
    chk("R7 off irq", {31'h0, irq}, 32'h0);
    chk("R10 inactive", {31'h0, act}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule